// File: doc/BRIEF.md
# Peripheral Access Protection Gate

This block stands between one APB-style master and up to sixteen peripheral ports. Each transfer carries a protection attribute that says whether it is secure or nonsecure and privileged or unprivileged. Every port has two configuration bits, a nonsecure marker and an unprivileged-permit flag. The gate checks each transfer against the bits of the port it selects. A transfer that passes is forwarded untouched, and the port's response comes back unchanged. A transfer that fails never reaches the port. The master instead gets a response at once: either an error, or a clean completion where reads return zero and writes are dropped. A global mode input picks which of the two.

Every refused transfer sets a sticky violation flag. This flag, ANDed with an enable input, forms an interrupt. A clear input resets the flag. While the clear input stays high, new violations are not recorded. A build-time mask can exempt chosen ports from the security comparison, leaving only the privilege check on those ports. Port selects come in already decoded, one per port. The configuration arrives as plain wires that the gate registers on every clock.

Top module: `ppg_gate`

## Requirements
- R1: When the selected port permits a transfer, the downstream bus carries the upstream address, write data, byte strobes, direction, enable and protection unchanged, the select is asserted only on that port, and that port's read data, ready and error are returned upstream unchanged.
- R2: Security attribute is PPROT bit 1 (0 = secure). For a port whose mask bit is 0, a transfer is refused when its secure flag equals the port's registered nonsecure bit.
- R3: For a port whose SEC_BYPASS_MASK bit is 1, the security comparison is skipped, so a transfer is decided by the privilege check alone.
- R4: Privilege is PPROT bit 0 (0 = unprivileged). An unprivileged transfer is refused whenever the port's registered unprivileged-permit bit is 0, whatever the security outcome.
- R5: A refused transfer never asserts any downstream select.
- R6: A refused transfer with the registered error mode at 1 returns ready 1 and error 1, without wait states.
- R7: A refused transfer with the registered error mode at 0 returns ready 1, error 0 and read data of all zeros.
- R8: A refused transfer in its access phase (select and enable high) sets the violation flag from the next clock edge on. The flag then stays set until it is cleared.
- R9: With the clear input high at a clock edge, the violation flag is 0 after that edge, and refused transfers seen at that edge are not recorded.
- R10: The interrupt output equals the violation flag AND the interrupt-enable input, with no extra register stage.
- R11: The per-port bits and the error mode are sampled from their inputs on every clock and act from the next cycle. Synchronous reset forces all of them, and the violation flag, to 0.
- R12: With no port selected, the upstream sees ready 1, error 0 and read data 0, and no downstream select is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ns_i | input | NPORT | Per-port nonsecure marker |
| cfg_upriv_i | input | NPORT | Per-port unprivileged-permit flag |
| err_mode_i | input | 1 | Refused-transfer response: 1 error, 0 read-zero/write-drop |
| irq_en_i | input | 1 | Interrupt enable |
| irq_clr_i | input | 1 | Violation clear and suppress |
| irq_o | output | 1 | Violation interrupt |
| psel_i | input | NPORT | Upstream one-hot port select |
| penable_i | input | 1 | Upstream access phase |
| pwrite_i | input | 1 | Upstream direction |
| paddr_i | input | AW | Upstream address |
| pwdata_i | input | DW | Upstream write data |
| pstrb_i | input | DW/8 | Upstream byte strobes |
| pprot_i | input | 3 | Upstream protection attribute |
| prdata_o | output | DW | Upstream read data |
| pready_o | output | 1 | Upstream ready |
| pslverr_o | output | 1 | Upstream error |
| d_psel_o | output | NPORT | Downstream per-port select |
| d_penable_o | output | 1 | Downstream access phase |
| d_pwrite_o | output | 1 | Downstream direction |
| d_paddr_o | output | AW | Downstream address |
| d_pwdata_o | output | DW | Downstream write data |
| d_pstrb_o | output | DW/8 | Downstream byte strobes |
| d_pprot_o | output | 3 | Downstream protection attribute |
| d_prdata_i | input | NPORT*DW | Downstream read data, port i at bits i*DW |
| d_pready_i | input | NPORT | Downstream ready per port |
| d_pslverr_i | input | NPORT | Downstream error per port |

## Verification
The bench builds the gate with all sixteen ports, a 16-bit address and a 32-bit data path. It sets SEC_BYPASS_MASK to 16'h0005, so ports 0 and 2 skip the security comparison while their neighbours keep it. Random transfers to every port then compare masked and unmasked ports under the same configuration. Other stretches hold the clear input high across refused transfers, switch the error mode, and reset in the middle of a run with every configuration input at 1.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  // PPROT: bit 1 set = nonsecure, bit 0 set = privileged
  typedef struct packed {
    logic ns;     // port configured nonsecure
    logic upriv;  // unprivileged access permitted
  } port_cfg_t;

  function automatic logic refuse(input logic bypass_sec, input port_cfg_t c,
                                  input logic [1:0] prot);
    logic sec_fail;
    logic priv_fail;
    sec_fail  = !bypass_sec && ((!prot[1]) == c.ns);
    priv_fail = !prot[0] && !c.upriv;
    return sec_fail || priv_fail;
  endfunction
endpackage

// File: rtl/ppg_port_check.sv
module ppg_port_check
  import ppg_pkg::*;
#(
  parameter bit BYPASS_SEC = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_ns_i,
  input  logic       cfg_upriv_i,
  input  logic       psel_i,
  input  logic [1:0] prot_i,
  output logic       refused_o,
  output logic       fwd_sel_o
);
  port_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else begin
      cfg_q.ns    <= cfg_ns_i;
      cfg_q.upriv <= cfg_upriv_i;
    end
  end

  logic hit;
  always_comb begin
    hit       = refuse(BYPASS_SEC, cfg_q, prot_i);
    refused_o = psel_i && hit;
    fwd_sel_o = psel_i && !hit;
  end

  AST_UNPRIV_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (psel_i && !prot_i[0] && !cfg_q.upriv) |-> !fwd_sel_o); // R4

  generate
    if (!BYPASS_SEC) begin : g_sec_chk
      AST_SEC_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (psel_i && ((!prot_i[1]) == cfg_q.ns)) |-> !fwd_sel_o); // R2
    end else begin : g_sec_skip
      AST_SEC_SKIPPED: assert property (@(posedge clk) disable iff (rst)
        (psel_i && prot_i[0]) |-> fwd_sel_o); // R3
    end
  endgenerate
endmodule

// File: rtl/ppg_resp_mux.sv
module ppg_resp_mux #(
  parameter int NPORT = 16,
  parameter int DW    = 32
) (
  input  logic [NPORT-1:0]    psel_i,
  input  logic                refused_i,
  input  logic                err_mode_q_i,
  input  logic [NPORT*DW-1:0] d_prdata_i,
  input  logic [NPORT-1:0]    d_pready_i,
  input  logic [NPORT-1:0]    d_pslverr_i,
  output logic [DW-1:0]       prdata_o,
  output logic                pready_o,
  output logic                pslverr_o
);
  always_comb begin
    prdata_o  = '0;
    pready_o  = 1'b1;
    pslverr_o = 1'b0;
    if (refused_i) begin
      pslverr_o = err_mode_q_i;
    end else begin
      for (int i = 0; i < NPORT; i++) begin
        if (psel_i[i]) begin
          prdata_o  = d_prdata_i[i*DW +: DW];
          pready_o  = d_pready_i[i];
          pslverr_o = d_pslverr_i[i];
        end
      end
    end
  end
endmodule

// File: rtl/ppg_viol_status.sv
module ppg_viol_status (
  input  logic clk,
  input  logic rst,
  input  logic viol_i,
  input  logic clr_i,
  input  logic en_i,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) flag_q <= 1'b0;
    else if (viol_i)  flag_q <= 1'b1;
  end

  assign irq_o = flag_q && en_i;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_i) |=> flag_q); // R8
  AST_VIOL_SETS: assert property (@(posedge clk) disable iff (rst)
    (viol_i && !clr_i) |=> flag_q); // R8
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !flag_q); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    !en_i |-> !irq_o); // R10
endmodule

// File: rtl/ppg_gate.sv
module ppg_gate #(
  parameter int               NPORT           = 16,
  parameter int               AW              = 16,
  parameter int               DW              = 32,
  parameter logic [NPORT-1:0] SEC_BYPASS_MASK = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NPORT-1:0]    cfg_ns_i,
  input  logic [NPORT-1:0]    cfg_upriv_i,
  input  logic                err_mode_i,
  input  logic                irq_en_i,
  input  logic                irq_clr_i,
  output logic                irq_o,
  input  logic [NPORT-1:0]    psel_i,
  input  logic                penable_i,
  input  logic                pwrite_i,
  input  logic [AW-1:0]       paddr_i,
  input  logic [DW-1:0]       pwdata_i,
  input  logic [DW/8-1:0]     pstrb_i,
  input  logic [2:0]          pprot_i,
  output logic [DW-1:0]       prdata_o,
  output logic                pready_o,
  output logic                pslverr_o,
  output logic [NPORT-1:0]    d_psel_o,
  output logic                d_penable_o,
  output logic                d_pwrite_o,
  output logic [AW-1:0]       d_paddr_o,
  output logic [DW-1:0]       d_pwdata_o,
  output logic [DW/8-1:0]     d_pstrb_o,
  output logic [2:0]          d_pprot_o,
  input  logic [NPORT*DW-1:0] d_prdata_i,
  input  logic [NPORT-1:0]    d_pready_i,
  input  logic [NPORT-1:0]    d_pslverr_i
);
  logic             err_mode_q;
  logic [NPORT-1:0] refused_vec;
  logic             refused_any;

  always_ff @(posedge clk) begin
    if (rst) err_mode_q <= 1'b0;
    else     err_mode_q <= err_mode_i;
  end

  genvar g;
  generate
    for (g = 0; g < NPORT; g++) begin : g_port
      ppg_port_check #(.BYPASS_SEC(SEC_BYPASS_MASK[g])) u_chk (
        .clk        (clk),
        .rst        (rst),
        .cfg_ns_i   (cfg_ns_i[g]),
        .cfg_upriv_i(cfg_upriv_i[g]),
        .psel_i     (psel_i[g]),
        .prot_i     (pprot_i[1:0]),
        .refused_o  (refused_vec[g]),
        .fwd_sel_o  (d_psel_o[g])
      );
    end
  endgenerate

  assign refused_any = |refused_vec;

  assign d_penable_o = penable_i;
  assign d_pwrite_o  = pwrite_i;
  assign d_paddr_o   = paddr_i;
  assign d_pwdata_o  = pwdata_i;
  assign d_pstrb_o   = pstrb_i;
  assign d_pprot_o   = pprot_i;

  ppg_resp_mux #(.NPORT(NPORT), .DW(DW)) u_mux (
    .psel_i       (psel_i),
    .refused_i    (refused_any),
    .err_mode_q_i (err_mode_q),
    .d_prdata_i   (d_prdata_i),
    .d_pready_i   (d_pready_i),
    .d_pslverr_i  (d_pslverr_i),
    .prdata_o     (prdata_o),
    .pready_o     (pready_o),
    .pslverr_o    (pslverr_o)
  );

  ppg_viol_status u_stat (
    .clk   (clk),
    .rst   (rst),
    .viol_i(refused_any && penable_i),
    .clr_i (irq_clr_i),
    .en_i  (irq_en_i),
    .irq_o (irq_o)
  );

  AST_ERR_RESP: assert property (@(posedge clk) disable iff (rst)
    (refused_any && err_mode_q) |-> (pready_o && pslverr_o)); // R6
  AST_RAZ_RESP: assert property (@(posedge clk) disable iff (rst)
    (refused_any && !err_mode_q) |-> (pready_o && !pslverr_o && prdata_o == '0)); // R7
  AST_IDLE_RESP: assert property (@(posedge clk) disable iff (rst)
    (psel_i == '0) |-> (pready_o && !pslverr_o && d_psel_o == '0)); // R12
  AST_SEL_SUBSET: assert property (@(posedge clk) disable iff (rst)
    (d_psel_o & ~psel_i) == '0); // R5
endmodule

// File: tb/ppg_gate_tb.sv
module ppg_gate_tb_top;
  localparam int NPORT = 16;
  localparam int AW    = 16;
  localparam int DW    = 32;
  localparam logic [NPORT-1:0] BYP = 16'h0005;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NPORT-1:0] cfg_ns, cfg_up;
  logic err_mode, irq_en, irq_clr, irq;
  logic [NPORT-1:0] psel;
  logic penable, pwrite;
  logic [AW-1:0] paddr;
  logic [DW-1:0] pwdata, prdata;
  logic [DW/8-1:0] pstrb;
  logic [2:0] pprot;
  logic pready, pslverr;
  logic [NPORT-1:0] d_psel;
  logic d_penable, d_pwrite;
  logic [AW-1:0] d_paddr;
  logic [DW-1:0] d_pwdata;
  logic [DW/8-1:0] d_pstrb;
  logic [2:0] d_pprot;
  logic [NPORT*DW-1:0] d_prdata;
  logic [NPORT-1:0] d_pready, d_pslverr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ppg_gate #(.NPORT(NPORT), .AW(AW), .DW(DW), .SEC_BYPASS_MASK(BYP)) dut_i (
    .clk(clk), .rst(rst), .cfg_ns_i(cfg_ns), .cfg_upriv_i(cfg_up),
    .err_mode_i(err_mode), .irq_en_i(irq_en), .irq_clr_i(irq_clr), .irq_o(irq),
    .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite), .paddr_i(paddr),
    .pwdata_i(pwdata), .pstrb_i(pstrb), .pprot_i(pprot),
    .prdata_o(prdata), .pready_o(pready), .pslverr_o(pslverr),
    .d_psel_o(d_psel), .d_penable_o(d_penable), .d_pwrite_o(d_pwrite),
    .d_paddr_o(d_paddr), .d_pwdata_o(d_pwdata), .d_pstrb_o(d_pstrb),
    .d_pprot_o(d_pprot), .d_prdata_i(d_prdata), .d_pready_i(d_pready),
    .d_pslverr_i(d_pslverr)
  );

  // reference model state
  bit m_ns[NPORT];
  bit m_up[NPORT];
  bit m_err;
  bit m_flag;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int sel_idx();
    for (int i = 0; i < NPORT; i++) if (psel[i]) return i;
    return -1;
  endfunction

  function automatic bit model_refused();
    int s;
    bit sec_fail, priv_fail;
    s = sel_idx();
    if (s < 0) return 0;
    sec_fail  = !BYP[s] && ((pprot[1] == 1'b0) == m_ns[s]);
    priv_fail = (pprot[0] == 1'b0) && !m_up[s];
    return sec_fail || priv_fail;
  endfunction

  task automatic compare();
    int s;
    bit rf;
    logic [NPORT-1:0] e_sel;
    s  = sel_idx();
    rf = model_refused();
    e_sel = (s >= 0 && !rf) ? (16'h1 << s) : '0;
    if (s < 0) begin
      chk(d_psel == '0 && pready && !pslverr && prdata == '0, "R12 idle response",
          {d_psel, pready, pslverr}, 64'h2);
    end else if (rf) begin
      chk(d_psel == '0, "R5 refused select", d_psel, 0);
      if (m_err)
        chk(pready && pslverr, "R6 error response", {pready, pslverr}, 2'b11);
      else
        chk(pready && !pslverr && prdata == '0, "R7 read-zero response",
            {prdata, pready, pslverr}, 2'b10);
    end else begin
      if (BYP[s] && pprot[0])
        chk(d_psel == e_sel, "R3 masked port forwarded", d_psel, e_sel);
      else if (!pprot[0])
        chk(d_psel == e_sel, "R4 unprivileged permitted", d_psel, e_sel);
      else
        chk(d_psel == e_sel, "R2 security match forwarded", d_psel, e_sel);
      chk(prdata == d_prdata[s*DW +: DW] && pready == d_pready[s] && pslverr == d_pslverr[s],
          "R1 response returned", {prdata, pready, pslverr},
          {d_prdata[s*DW +: DW], d_pready[s], d_pslverr[s]});
    end
    if (s >= 0 && rf && (BYP[s] || pprot[0]))
      chk(d_psel == '0, "R2 R4 refusal cause", d_psel, 0);
    chk(d_penable == penable && d_pwrite == pwrite && d_paddr == paddr &&
        d_pwdata == pwdata && d_pstrb == pstrb && d_pprot == pprot,
        "R1 request fields", {d_paddr, d_pstrb, d_pprot}, {paddr, pstrb, pprot});
    chk(irq == (m_flag && irq_en), "R10 R8 R9 interrupt", irq, m_flag && irq_en);
  endtask

  task automatic model_edge();
    bit rf;
    rf = model_refused();
    if (rst) begin
      for (int i = 0; i < NPORT; i++) begin m_ns[i] = 0; m_up[i] = 0; end
      m_err = 0; m_flag = 0;
    end else begin
      m_flag = irq_clr ? 1'b0 : (m_flag || (rf && penable));
      for (int i = 0; i < NPORT; i++) begin m_ns[i] = cfg_ns[i]; m_up[i] = cfg_up[i]; end
      m_err = err_mode;
    end
  endtask

  task automatic drive(input int cyc);
    rst = (cyc < 4) || (cyc >= 1500 && cyc < 1502);
    if (rst) begin
      cfg_ns = '1; cfg_up = '1; err_mode = 1'b1;   // R11 ignored while in reset
    end else if (($urandom % 16) == 0 || cyc == 4) begin
      cfg_ns = 16'($urandom); cfg_up = 16'($urandom); err_mode = 1'($urandom);
    end
    irq_en  = (cyc % 300) < 250;
    irq_clr = ((cyc % 200) >= 100 && (cyc % 200) < 110) || (($urandom % 64) == 0);
    if (($urandom % 5) == 0) psel = '0;
    else psel = 16'h1 << ($urandom % NPORT);
    penable = 1'($urandom);
    pwrite  = 1'($urandom);
    paddr   = AW'($urandom);
    pwdata  = $urandom;
    pstrb   = 4'($urandom);
    pprot   = 3'($urandom);
    for (int i = 0; i < NPORT; i++) d_prdata[i*DW +: DW] = $urandom;
    d_pready  = 16'($urandom);
    d_pslverr = 16'($urandom);
  endtask

  initial begin
    cfg_ns = '1; cfg_up = '1; err_mode = 1'b1;
    drive(0);
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(posedge clk);
      #1;
      model_edge();
      if (cyc == 2) begin
        // R11: reset state with all configuration inputs high
        chk(irq == 1'b0, "R11 reset interrupt", irq, 0);
      end
      @(negedge clk);
      drive(cyc + 1);
      #5;
      compare();
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule